// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between a register bus and an SPI shift engine. It holds one 64-byte transmit queue and one 64-byte receive queue. From their fill levels it derives the status flags and the interrupt line. Bus writes to the data address feed the transmit queue, and bus reads from that address drain the receive queue. The shift engine uses a pop strobe to take bytes from the transmit queue and a push strobe to deposit received bytes into the receive queue.

In byte mode, each data access moves one byte in bits 7:0. When the word-mode enable is set, each data access moves four bytes packed little-endian: the byte in bits 7:0 is sent first or was received first. In word mode a length register limits how many bytes the engine may take, so a final word can carry only one to three meaningful bytes. Software can empty either queue through self-clearing command bits in the control word. Two separately enabled conditions drive the interrupt line: transfer complete, and receive queue three-quarters full.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: A byte-mode write to address 1 appends bits 7:0 to the transmit queue. The engine receives the bytes in write order. Status bit 18 is 1 while the queue holds fewer than 64 bytes. A write is ignored when the queue already holds 64 bytes at the start of that cycle.
- R2: An engine push appends `eng_rx_byte` to the receive queue, and a push into a full queue is dropped. Status bit 17 is 1 when the queue holds at least one byte. Status bit 20 is 1 when it holds 64 bytes.
- R3: Status bit 19 is 1 when the receive queue holds 48 or more bytes.
- R4: Writing address 0 with bit 4 set empties the transmit queue, and with bit 5 set empties the receive queue. A clear overrides any push or pop in the same cycle. Both bits read back as 0.
- R5: Status bit 16 (complete) is 1 when the transmit queue is empty and `eng_busy` is low. `irq` is 1 when either of these holds: control bit 9 is set and complete is 1, or control bit 10 is set and status bit 19 is 1.
- R6: With control bit 8 set, a write to address 1 appends four bytes, bits 7:0 first. The write is ignored unless at least four slots are free.
- R7: A read of address 1 removes bytes from the receive queue. In byte mode it removes one byte, returned in bits 7:0. In word mode it removes up to four bytes, the oldest in bits 7:0, with any missing bytes read as zero. A read of an empty queue returns 0.
- R8: Address 2 holds the length register. In word mode, each byte the engine takes decrements it, and `tx_avail` stays low while it is zero, so leftover padding bytes are never sent.
- R9: An engine pop and a bus write to the transmit queue in the same cycle both take effect. The same holds for an engine push and a bus read of the receive queue.
- R10: After reset both queues are empty, the control fields and the length are 0, the status word reads 0x00050000, and `irq` and `tx_avail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on address 1) |
| bus_addr | input | 2 | 0 control/status, 1 data, 2 length |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Interrupt request |
| eng_busy | input | 1 | Shift engine is mid-byte |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| tx_avail | output | 1 | A transmit byte may be taken |
| tx_byte | output | 8 | Head transmit byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |

## Verification
The cases that need care are those where the bus and the shift engine act on the same queue in one cycle. One is a data write while the engine pops the transmit head. The other is a data read while the engine pushes a new received byte. The bench drives both strobes between the same pair of clock edges. It then drains the affected queue and compares the full byte order and the final empty flags with the expected sequence, so a lost, duplicated or reordered byte shows up. A receive-level sweep from 0 to 64 checks every status flag at every level against thresholds computed in the bench.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_DATA = 2'd1,
        A_LEN  = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    localparam int unsigned B_CLR_TX  = 4;
    localparam int unsigned B_CLR_RX  = 5;
    localparam int unsigned B_WORD    = 8;
    localparam int unsigned B_IE_DONE = 9;
    localparam int unsigned B_IE_RXR  = 10;
    localparam int unsigned B_DONE    = 16;
    localparam int unsigned B_RXD     = 17;
    localparam int unsigned B_TXD     = 18;
    localparam int unsigned B_RXR     = 19;
    localparam int unsigned B_RXF     = 20;

    typedef struct packed {
        logic word_mode;
        logic ie_done;
        logic ie_rxr;
    } ctrl_t;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned LANES     = 4,
    parameter int unsigned IN_LANES  = 4,
    parameter int unsigned OUT_LANES = 4,
    parameter int unsigned CW        = $clog2(DEPTH + 1),
    parameter int unsigned NW        = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic [NW-1:0]          push_n,
    input  logic [8*IN_LANES-1:0]  push_data,
    input  logic [NW-1:0]          pop_n,
    output logic [8*OUT_LANES-1:0] head,
    output logic [CW-1:0]          level
);

    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] level;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [7:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            st_d.wptr  = st_q.wptr + AW'(push_n);
            st_d.rptr  = st_q.rptr + AW'(pop_n);
            st_d.level = st_q.level + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(IN_LANES); i++) begin
            if (!clear && (NW'(i) < push_n))
                mem[st_q.wptr + AW'(i)] <= push_data[8*i +: 8];
        end
    end

    for (genvar g = 0; g < int'(OUT_LANES); g++) begin : g_head
        assign head[8*g +: 8] = mem[st_q.rptr + AW'(g)];
    end

    assign level = st_q.level;

endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags #(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned RXR_LEVEL = 48,
    parameter int unsigned CW        = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    input  logic          eng_busy,
    input  logic          ie_done,
    input  logic          ie_rxr,
    output logic          done,
    output logic          txd,
    output logic          rxd,
    output logic          rxr,
    output logic          rxf,
    output logic          irq
);

    always_comb begin
        done = (tx_level == '0) && !eng_busy;
        txd  = tx_level < CW'(DEPTH);
        rxd  = rx_level != '0;
        rxr  = rx_level >= CW'(RXR_LEVEL);
        rxf  = rx_level == CW'(DEPTH);
        irq  = (ie_done && done) || (ie_rxr && rxr);
    end

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LANES = 4,
    parameter int unsigned LENW  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [1:0]           bus_addr,
    input  logic [8*LANES-1:0]   bus_wdata,
    output logic [8*LANES-1:0]   bus_rdata,
    output logic                 irq,
    input  logic                 eng_busy,
    input  logic                 eng_tx_pop,
    output logic                 tx_avail,
    output logic [7:0]           tx_byte,
    input  logic                 eng_rx_push,
    input  logic [7:0]           eng_rx_byte
);

    localparam int unsigned DW        = 8 * LANES;
    localparam int unsigned CW        = $clog2(DEPTH + 1);
    localparam int unsigned NW        = $clog2(LANES + 1);
    localparam int unsigned RXR_LEVEL = (DEPTH * 3) / 4;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [LENW-1:0] len;
    } unit_st_t;

    unit_st_t st_d, st_q;

    reg_addr_e       addr;
    logic            wr_ctrl, wr_data, wr_len, rd_data;
    logic            clr_tx, clr_rx;
    logic [CW-1:0]   tx_level, rx_level, tx_free;
    logic [NW-1:0]   tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [DW-1:0]   rx_head;
    logic            dma_on, ie_done_on, ie_rxr_on;
    logic [LENW-1:0] len_now;
    logic            f_done, f_txd, f_rxd, f_rxr, f_rxf;

    assign dma_on     = st_q.ctrl.word_mode;
    assign ie_done_on = st_q.ctrl.ie_done;
    assign ie_rxr_on  = st_q.ctrl.ie_rxr;
    assign len_now    = st_q.len;

    always_comb begin
        addr    = reg_addr_e'(bus_addr);
        wr_ctrl = bus_wr && (addr == A_CTRL);
        wr_data = bus_wr && (addr == A_DATA);
        wr_len  = bus_wr && (addr == A_LEN);
        rd_data = bus_rd && (addr == A_DATA);
        clr_tx  = wr_ctrl && bus_wdata[B_CLR_TX];
        clr_rx  = wr_ctrl && bus_wdata[B_CLR_RX];
        tx_free = CW'(DEPTH) - tx_level;

        tx_push_n = '0;
        if (wr_data) begin
            if (dma_on) tx_push_n = (tx_free >= CW'(LANES)) ? NW'(LANES) : '0;
            else        tx_push_n = (tx_free != '0) ? NW'(1) : '0;
        end

        tx_avail = (tx_level != '0) && (!dma_on || (len_now != '0));
        tx_pop_n = (eng_tx_pop && tx_avail) ? NW'(1) : '0;

        rx_push_n = (eng_rx_push && (rx_level != CW'(DEPTH))) ? NW'(1) : '0;

        rx_pop_n = '0;
        if (rd_data) begin
            if (dma_on) rx_pop_n = (rx_level >= CW'(LANES)) ? NW'(LANES) : NW'(rx_level);
            else        rx_pop_n = (rx_level != '0) ? NW'(1) : '0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.word_mode = bus_wdata[B_WORD];
            st_d.ctrl.ie_done   = bus_wdata[B_IE_DONE];
            st_d.ctrl.ie_rxr    = bus_wdata[B_IE_RXR];
        end
        if (wr_len)
            st_d.len = bus_wdata[LENW-1:0];
        else if (dma_on && (tx_pop_n != '0))
            st_d.len = st_q.len - LENW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    spi_byte_fifo #(
        .DEPTH(DEPTH), .LANES(LANES), .IN_LANES(LANES), .OUT_LANES(1), .CW(CW), .NW(NW)
    ) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clear(clr_tx),
        .push_n(tx_push_n), .push_data(bus_wdata),
        .pop_n(tx_pop_n), .head(tx_byte), .level(tx_level)
    );

    spi_byte_fifo #(
        .DEPTH(DEPTH), .LANES(LANES), .IN_LANES(1), .OUT_LANES(LANES), .CW(CW), .NW(NW)
    ) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clear(clr_rx),
        .push_n(rx_push_n), .push_data(eng_rx_byte),
        .pop_n(rx_pop_n), .head(rx_head), .level(rx_level)
    );

    spi_fifo_flags #(
        .DEPTH(DEPTH), .RXR_LEVEL(RXR_LEVEL), .CW(CW)
    ) u_flags (
        .tx_level(tx_level), .rx_level(rx_level), .eng_busy(eng_busy),
        .ie_done(ie_done_on), .ie_rxr(ie_rxr_on),
        .done(f_done), .txd(f_txd), .rxd(f_rxd), .rxr(f_rxr), .rxf(f_rxf), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            A_CTRL: begin
                bus_rdata[B_WORD]    = dma_on;
                bus_rdata[B_IE_DONE] = ie_done_on;
                bus_rdata[B_IE_RXR]  = ie_rxr_on;
                bus_rdata[B_DONE]    = f_done;
                bus_rdata[B_RXD]     = f_rxd;
                bus_rdata[B_TXD]     = f_txd;
                bus_rdata[B_RXR]     = f_rxr;
                bus_rdata[B_RXF]     = f_rxf;
            end
            A_DATA: begin
                for (int i = 0; i < int'(LANES); i++)
                    bus_rdata[8*i +: 8] = (NW'(i) < rx_pop_n) ? rx_head[8*i +: 8] : 8'h00;
            end
            A_LEN:   bus_rdata = DW'(len_now);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_fifo_irq_unit_chk.sv
module spi_fifo_irq_unit_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LENW  = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [1:0]      bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            eng_tx_pop,
    input logic            tx_avail,
    input logic            irq,
    input logic [CW-1:0]   tx_level,
    input logic [CW-1:0]   rx_level,
    input logic [LENW-1:0] len_now,
    input logic            dma_on,
    input logic            ie_done_on,
    input logic            ie_rxr_on
);

    AST_TX_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= CW'(DEPTH)); // R1

    AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == CW'(DEPTH)) && !(bus_rd && bus_addr == 2'd1)
        && !(bus_wr && bus_addr == 2'd0 && bus_wdata[5])
        |=> rx_level == CW'(DEPTH)); // R2

    AST_CLEAR_TX: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 2'd0 && bus_wdata[4] |=> tx_level == '0); // R4

    AST_CLEAR_RX: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 2'd0 && bus_wdata[5] |=> rx_level == '0); // R4

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_done_on && !ie_rxr_on |-> !irq); // R5

    AST_LEN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        dma_on && eng_tx_pop && tx_avail && !(bus_wr && bus_addr == 2'd2)
        && !(bus_wr && bus_addr == 2'd0)
        |=> len_now == $past(len_now) - LENW'(1)); // R8

    AST_LEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_on && (len_now == '0) |-> !tx_avail); // R8

    AST_SAME_CYCLE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_on && eng_tx_pop && tx_avail && bus_wr && bus_addr == 2'd1
        && (tx_level < CW'(DEPTH))
        |=> tx_level == $past(tx_level)); // R9

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_unit_chk #(
    .DEPTH(DEPTH), .LENW(LENW), .DW(8 * LANES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .eng_tx_pop(eng_tx_pop),
    .tx_avail(tx_avail), .irq(irq), .tx_level(tx_level), .rx_level(rx_level),
    .len_now(len_now), .dma_on(dma_on), .ie_done_on(ie_done_on), .ie_rxr_on(ie_rxr_on)
);

// File: tb/tb_spi_fifo_irq_unit.sv
module tb_spi_fifo_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_avail;
    logic        eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [7:0]  tx_byte;
    logic [7:0]  eng_rx_byte = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_fifo_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_busy(eng_busy), .eng_tx_pop(eng_tx_pop),
        .tx_avail(tx_avail), .tx_byte(tx_byte),
        .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input int txl, input int rxl,
                                               input bit busy, input logic [31:0] ctrl);
        logic [31:0] s;
        s = ctrl & 32'h0000_0700;
        s[16] = (txl == 0) && !busy;
        s[17] = rxl > 0;
        s[18] = txl < 64;
        s[19] = rxl >= 48;
        s[20] = rxl == 64;
        return s;
    endfunction

    task automatic bwr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic epush(input logic [7:0] b);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_byte = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic epop(output logic [7:0] b);
        @(negedge clk);
        #1 b = tx_byte;
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        brd(2'd0, d); chk("R10 status", d, 32'h0005_0000);
        chk("R10 irq", {31'b0, irq}, 32'd0);
        chk("R10 tx_avail", {31'b0, tx_avail}, 32'd0);
        brd(2'd2, d); chk("R10 len", d, 32'd0);

        // R2 R3 receive level sweep
        for (int k = 0; k <= 64; k++) begin
            brd(2'd0, d); chk("R3 R2 rx sweep status", d, exp_status(0, k, 0, 0));
            if (k < 64) epush(8'((k * 5 + 1) & 255));
        end
        epush(8'hEE);
        brd(2'd0, d); chk("R2 full drop status", d, exp_status(0, 64, 0, 0));
        for (int k = 0; k < 64; k++) begin
            brd(2'd1, d); chk("R2 R7 rx order", d, 32'((k * 5 + 1) & 255));
        end
        brd(2'd1, d); chk("R7 empty read", d, 32'd0);

        // R1 transmit fill, overflow, drain
        for (int k = 0; k < 64; k++) begin
            bwr(2'd1, 32'((k * 3 + 7) & 255));
            brd(2'd0, d); chk("R1 tx fill status", d, exp_status(k + 1, 0, 0, 0));
        end
        bwr(2'd1, 32'h0000_00AB);
        for (int k = 0; k < 64; k++) begin
            epop(b); chk("R1 tx order", {24'b0, b}, 32'((k * 3 + 7) & 255));
        end
        #1 chk("R1 overflow ignored", {31'b0, tx_avail}, 32'd0);
        brd(2'd0, d); chk("R1 drained status", d, exp_status(0, 0, 0, 0));

        // R4 clear commands
        bwr(2'd1, 32'h11); bwr(2'd1, 32'h22);
        epush(8'h33); epush(8'h44);
        bwr(2'd0, 32'h0000_0030);
        brd(2'd0, d); chk("R4 clear both", d, 32'h0005_0000);

        // R5 interrupt enables
        bwr(2'd0, 32'h0000_0200);
        #1 chk("R5 irq on done", {31'b0, irq}, 32'd1);
        @(negedge clk); eng_busy = 1'b1;
        #1 chk("R5 irq busy", {31'b0, irq}, 32'd0);
        @(negedge clk); eng_busy = 1'b0;
        bwr(2'd0, 32'h0000_0400);
        #1 chk("R5 irq rxr empty", {31'b0, irq}, 32'd0);
        for (int k = 0; k < 47; k++) epush(8'(k));
        #1 chk("R3 R5 irq at 47", {31'b0, irq}, 32'd0);
        epush(8'h5A);
        #1 chk("R3 R5 irq at 48", {31'b0, irq}, 32'd1);
        bwr(2'd0, 32'h0000_0420);
        #1 chk("R4 R5 irq after clear", {31'b0, irq}, 32'd0);
        bwr(2'd0, 32'h0);

        // R6 R8 word-mode transmit with partial final word
        bwr(2'd0, 32'h0000_0100);
        bwr(2'd2, 32'd6);
        bwr(2'd1, 32'h4433_2211);
        bwr(2'd1, 32'h8877_6655);
        for (int k = 0; k < 6; k++) begin
            epop(b); chk("R6 R8 word order", {24'b0, b}, 32'(8'h11 * (k + 1)));
        end
        #1 chk("R8 stop at zero", {31'b0, tx_avail}, 32'd0);
        brd(2'd2, d); chk("R8 len zero", d, 32'd0);
        brd(2'd0, d); chk("R8 padding left", d, exp_status(2, 0, 0, 32'h100));
        bwr(2'd0, 32'h0000_0110);
        brd(2'd0, d); chk("R4 clear bit reads 0", d, exp_status(0, 0, 0, 32'h100));

        // R6 word write with only three free slots
        bwr(2'd0, 32'h0);
        for (int k = 0; k < 61; k++) bwr(2'd1, 32'(k));
        bwr(2'd0, 32'h0000_0100);
        bwr(2'd1, 32'hDEAD_BEEF);
        brd(2'd0, d); chk("R6 word write ignored", d, exp_status(61, 0, 0, 32'h100));
        bwr(2'd0, 32'h0000_0110);

        // R7 word-mode read
        for (int k = 0; k < 6; k++) epush(8'(8'hA0 + k));
        brd(2'd1, d); chk("R7 word read full", d, 32'hA3A2_A1A0);
        brd(2'd1, d); chk("R7 word read partial", d, 32'h0000_A5A4);
        brd(2'd1, d); chk("R7 word read empty", d, 32'd0);

        // R9 same-cycle transmit write and engine pop
        bwr(2'd0, 32'h0);
        bwr(2'd1, 32'h01); bwr(2'd1, 32'h02);
        @(negedge clk);
        #1 b = tx_byte;
        eng_tx_pop = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h03;
        @(negedge clk);
        eng_tx_pop = 1'b0; bus_wr = 1'b0;
        chk("R9 tx pop head", {24'b0, b}, 32'h01);
        epop(b); chk("R9 tx second", {24'b0, b}, 32'h02);
        epop(b); chk("R9 tx third", {24'b0, b}, 32'h03);
        #1 chk("R9 tx empty", {31'b0, tx_avail}, 32'd0);

        // R9 same-cycle receive push and bus read
        epush(8'h55);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_byte = 8'h66; bus_rd = 1'b1; bus_addr = 2'd1;
        #1 d = bus_rdata;
        @(negedge clk);
        eng_rx_push = 1'b0; bus_rd = 1'b0;
        chk("R9 rx read old", d, 32'h55);
        brd(2'd1, d); chk("R9 rx read new", d, 32'h66);
        brd(2'd0, d); chk("R9 rx empty", d, exp_status(0, 0, 0, 0));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule